// File: doc/BRIEF.md
# Zero-Injected Stochastic Bitstream Generator

This block turns a 4-bit unsigned number into a unipolar stochastic bitstream, one bit per accepted transfer. The share of ones in the stream approximates the number divided by 16. At full length (16 bits) the count of ones equals the number exactly, whatever nonzero seed is chosen.

A start strobe captures the number, a seed and a length code. The generator then loads a 4-bit maximal-length shift register with the seed. It emits a forced zero as the first bit. Each later bit is the result of comparing the captured number against the register, and the register steps once after every comparison bit is consumed. Shorter streams are the leading part of the full sequence, so the same hardware serves every length.

The output is a valid/ready stream with a last marker. While `bs_valid_o` is high and `bs_ready_i` is low, the bit, the marker and the internal sequence stay frozen. The transfer takes place on a rising edge where both are high. The start strobe is plain control and is only honoured while no stream is in flight.

Top module: `zinj_bitstream_gen`

## Requirements
- R1: After reset, `bs_valid_o` and `bs_last_o` are low.
- R2: A start strobe seen on a rising edge while no stream is active captures value, seed and length code, and `bs_valid_o` is high from the next cycle on.
- R3: The first bit of every stream is 0.
- R4: On start the register is loaded with the seed. After each transferred comparison bit it steps as next = {s[2:0], s[3]^s[2]}. Bit k (k ≥ 1) is 1 when value ≥ the register state after k−1 steps.
- R5: With length code 6 the stream holds exactly `value` ones, for every value 0..15 and every seed 1..15.
- R6: Length code c in 0..6 gives a stream of 4+2c bits; code 7 gives 16 bits.
- R7: `bs_last_o` is high only with the final bit. `bs_valid_o` is low in the cycle after the final transfer.
- R8: While `bs_valid_o` is high and `bs_ready_i` is low, `bs_bit_o` and `bs_last_o` hold and the sequence does not advance.
- R9: A start strobe while a stream is active is ignored; the running stream continues unchanged.
- R10: Seed 0 is replaced by 1 and gives the same stream as seed 1.
- R11: Repeating a start with the same value, seed and length reproduces the same stream bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a stream (ignored while one is active) |
| value_i | input | 4 | Unsigned number to encode |
| seed_i | input | 4 | Shift register seed (0 treated as 1) |
| len_sel_i | input | 3 | Stream length code, length = 4+2·code, code 7 = 16 |
| bs_valid_o | output | 1 | Stream bit is valid |
| bs_ready_i | input | 1 | Consumer accepts the bit |
| bs_bit_o | output | 1 | Stochastic bit |
| bs_last_o | output | 1 | Marks the final bit of the stream |

## Verification
The first bit is due one cycle after the edge that samples the start strobe. Each later bit is due in the cycle after the previous transfer, and valid drops one cycle after the final transfer. The bench drives inputs on the falling edge and samples outputs there too. It holds ready low during the start cycle so that the first bit is seen before any transfer. It then compares every transferred bit with a model of the shift-register sequence and checks the stream length, the last marker and the idle cycle after it, with and without stalls.

// File: rtl/zinj_pkg.sv
package zinj_pkg;
  localparam int VAL_W     = 4;
  localparam int LEN_SEL_W = 3;
  localparam int MIN_LEN   = 4;
  localparam int LEN_STEP  = 2;

  typedef enum logic {ST_IDLE, ST_RUN} run_e;
endpackage

// File: rtl/zinj_lfsr.sv
module zinj_lfsr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic         fb;
  logic [W-1:0] seed_safe;

  generate
    if (W == 3) begin : g_w3
      assign fb = state_q[2] ^ state_q[1];
    end else if (W == 5) begin : g_w5
      assign fb = state_q[4] ^ state_q[2];
    end else begin : g_w4
      assign fb = state_q[3] ^ state_q[2];
    end
  endgenerate

  assign seed_safe = (seed == '0) ? W'(1) : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= W'(1);
    else if (load) state_q <= seed_safe;
    else if (step) state_q <= {state_q[W-2:0], fb};
  end

  assign state = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R4
  AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state_q)); // R8
endmodule

// File: rtl/zinj_len_ctrl.sv
module zinj_len_ctrl
  import zinj_pkg::*;
#(
  parameter int W     = VAL_W,
  parameter int SEL_W = LEN_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic [SEL_W-1:0] len_sel,
  input  logic             fire,
  output logic             active,
  output logic             first,
  output logic             last
);
  localparam int MAX_LEN = 1 << W;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int MAX_SEL = (MAX_LEN - MIN_LEN) / LEN_STEP;

  run_e             st_q;
  logic [CNT_W-1:0] len_q, len_d, idx_q;

  always_comb begin
    if (int'(len_sel) > MAX_SEL) len_d = CNT_W'(MAX_LEN);
    else                         len_d = CNT_W'(MIN_LEN + LEN_STEP * int'(len_sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      len_q <= CNT_W'(MAX_LEN);
      idx_q <= '0;
    end else if (st_q == ST_IDLE) begin
      if (start_ok) begin
        st_q  <= ST_RUN;
        len_q <= len_d;
        idx_q <= '0;
      end
    end else if (fire) begin
      if (last) st_q <= ST_IDLE;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign active = (st_q == ST_RUN);
  assign first  = (idx_q == '0);
  assign last   = active && (idx_q == len_q - 1'b1);

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx_q < len_q)); // R6
  AST_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(len_q)); // R9
endmodule

// File: rtl/zinj_bitstream_gen.sv
module zinj_bitstream_gen
  import zinj_pkg::*;
#(
  parameter int W     = VAL_W,
  parameter int SEL_W = LEN_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [W-1:0]     value_i,
  input  logic [W-1:0]     seed_i,
  input  logic [SEL_W-1:0] len_sel_i,
  output logic             bs_valid_o,
  input  logic             bs_ready_i,
  output logic             bs_bit_o,
  output logic             bs_last_o
);
  logic         active, first, last, start_ok, fire;
  logic [W-1:0] value_q, rnd;

  assign start_ok = start_i && !active;
  assign fire     = active && bs_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value_q <= '0;
    else if (start_ok) value_q <= value_i;
  end

  zinj_lfsr #(.W(W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_ok),
    .seed  (seed_i),
    .step  (fire && !first),
    .state (rnd)
  );

  zinj_len_ctrl #(.W(W), .SEL_W(SEL_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .len_sel  (len_sel_i),
    .fire     (fire),
    .active   (active),
    .first    (first),
    .last     (last)
  );

  assign bs_valid_o = active;
  assign bs_bit_o   = active && !first && (value_q >= rnd);
  assign bs_last_o  = last;

  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bs_valid_o) |-> !bs_bit_o); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_valid_o && !bs_ready_i) |=> (bs_valid_o && $stable(bs_bit_o) && $stable(bs_last_o))); // R8
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_valid_o && bs_ready_i && bs_last_o) |=> !bs_valid_o); // R7
  AST_STREAM_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_valid_o && !(bs_ready_i && bs_last_o)) |=> bs_valid_o); // R9
  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !bs_valid_o) |=> bs_valid_o); // R2
endmodule

// File: tb/zinj_bitstream_gen_tb_top.sv
module zinj_bitstream_gen_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [3:0] value = 0, seed = 1;
  logic [2:0] len_sel = 6;
  logic ready = 0;
  logic bs_valid, bs_bit, bs_last;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  zinj_bitstream_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .value_i(value), .seed_i(seed),
    .len_sel_i(len_sel), .bs_valid_o(bs_valid), .bs_ready_i(ready),
    .bs_bit_o(bs_bit), .bs_last_o(bs_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(logic [3:0] v, logic [3:0] s, int k);
    logic [3:0] st = (s == 0) ? 4'd1 : s;
    if (k == 0) return 1'b0;
    for (int j = 1; j < k; j++) st = {st[2:0], st[3] ^ st[2]};
    return v >= st;
  endfunction

  function automatic int exp_len(logic [2:0] sel);
    return (sel == 3'd7) ? 16 : 4 + 2 * int'(sel);
  endfunction

  task automatic begin_stream(input logic [3:0] v, input logic [3:0] s, input logic [2:0] sel);
    @(negedge clk);
    ready = 0; value = v; seed = s; len_sel = sel; start = 1;
    @(negedge clk);
    start = 0;
    chk(bs_valid == 1'b1, "R2 valid after start", int'(bs_valid), 1);
  endtask

  task automatic collect(input logic [3:0] v, input logic [3:0] s, input logic [2:0] sel,
                         input bit stall, input bit poke_start,
                         output int ones, output logic [15:0] bits);
    int nb = 0, guard = 0;
    bit done = 0;
    ones = 0; bits = '0;
    while (!done && guard < 400) begin
      guard++;
      ready = stall ? (guard % 3 != 0) : 1'b1;
      if (poke_start && nb == 3) begin
        start = 1; value = ~v; seed = s + 4'd3; len_sel = 3'd0;
      end else start = 0;
      #1;
      if (bs_valid && ready) begin
        chk(bs_bit == exp_bit(v, s, nb), (nb == 0) ? "R3 first bit" : "R4 bit value",
            int'(bs_bit), int'(exp_bit(v, s, nb)));
        chk(bs_last == (nb == exp_len(sel) - 1), "R7 last marker", int'(bs_last),
            int'(nb == exp_len(sel) - 1));
        bits[nb[3:0]] = bs_bit;
        ones += int'(bs_bit);
        nb++;
        if (bs_last || nb >= 17) done = 1;
      end
      @(negedge clk);
    end
    start = 0; ready = 0;
    chk(done, "R7 stream ended", int'(done), 1);
    chk(nb == exp_len(sel), "R6 stream length", nb, exp_len(sel));
    chk(!bs_valid, "R7 idle after last", int'(bs_valid), 0);
  endtask

  task automatic t_reset();
    chk(!bs_valid, "R1 valid at reset", int'(bs_valid), 0);
    chk(!bs_last, "R1 last at reset", int'(bs_last), 0);
  endtask

  task automatic t_full_all();
    int ones; logic [15:0] b;
    for (int s = 1; s < 16; s++)
      for (int v = 0; v < 16; v++) begin
        begin_stream(4'(v), 4'(s), 3'd6);
        collect(4'(v), 4'(s), 3'd6, 0, 0, ones, b);
        chk(ones == v, "R5 ones count", ones, v);
      end
  endtask

  task automatic t_lengths();
    int ones; logic [15:0] b;
    for (int c = 0; c < 8; c++) begin
      begin_stream(4'd9, 4'd9, 3'(c));
      collect(4'd9, 4'd9, 3'(c), 0, 0, ones, b); // R6
    end
  endtask

  task automatic t_backpressure();
    int ones; logic [15:0] b;
    begin_stream(4'd11, 4'd5, 3'd6);
    collect(4'd11, 4'd5, 3'd6, 1, 0, ones, b);
    chk(ones == 11, "R8 ones under stalls", ones, 11);
  endtask

  task automatic t_start_busy();
    int ones; logic [15:0] b;
    begin_stream(4'd6, 4'd12, 3'd6);
    collect(4'd6, 4'd12, 3'd6, 0, 1, ones, b);
    chk(ones == 6, "R9 ignored restart", ones, 6);
  endtask

  task automatic t_seed_zero();
    int o0, o1; logic [15:0] b0, b1;
    begin_stream(4'd7, 4'd0, 3'd2);
    collect(4'd7, 4'd0, 3'd2, 0, 0, o0, b0);
    begin_stream(4'd7, 4'd1, 3'd2);
    collect(4'd7, 4'd1, 3'd2, 0, 0, o1, b1);
    chk(b0 == b1, "R10 seed 0 as seed 1", int'(b0), int'(b1));
  endtask

  task automatic t_repeat();
    int o0, o1; logic [15:0] b0, b1;
    begin_stream(4'd13, 4'd10, 3'd4);
    collect(4'd13, 4'd10, 3'd4, 0, 0, o0, b0);
    begin_stream(4'd13, 4'd10, 3'd4);
    collect(4'd13, 4'd10, 3'd4, 1, 0, o1, b1);
    chk(b0 == b1, "R11 repeatable stream", int'(b1), int'(b0));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_all();
    t_lengths();
    t_backpressure();
    t_start_busy();
    t_seed_zero();
    t_repeat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule